// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a watchdog timer that sits behind a small byte-addressed register bus. The host programs two 20-bit preload values, one for each stage, and then turns the timer on. A down counter takes the stage-1 preload and counts toward zero. On expiry it raises a timeout flag and restarts from the stage-2 preload. If the host does not reload in time, expiry of stage 2 either requests a system reset (warm or cold) or toggles a timeout pin.

The preload registers and the reload command are guarded by a two-write unlock key. Only the one write that comes straight after the key is accepted. A sticky lock bit freezes the configuration. It also stops software from disabling the timer until the next reset.

The bus uses a single write strobe with an address and a 32-bit data word. Byte-wide registers take their value from data bits [7:0]. Reads come back combinationally from the address.

Top module: `wdog_twostage`

## Requirements
- R1: Writing byte 0x80 and then byte 0x86 to offset 0x0C opens the key. Exactly one following write to a protected offset (0x00 stage-1 preload, 0x04 stage-2 preload, 0x0D command) is accepted. Any later protected write is dropped until the key is given again. Preloads read back at their own offsets in bits [19:0].
- R2: A protected write is dropped if no open key comes just before it. Any other write between the two key bytes cancels the partial key, and so does a wrong second byte.
- R3: In a keyed write to 0x0D, bit 0 restarts stage 1 from the stage-1 preload (this also applies during stage 2), and bit 1 clears the timeout flag. The flag reads back at offset 0x0C bit 9.
- R4: In the lock register (0x18), bit 0 is the lock and bit 1 is the timer enable. Writing enable from 0 to 1 loads stage 1. Once the lock bit is set, writes to 0x18 are ignored, including a write that clears the enable, until reset.
- R5: While locked, writes to the control register (0x10) and keyed preload writes are ignored. Reloads still work.
- R6: With control bit 2 set, a preload N gives (N+1)·2^FRAC_W clock cycles from the load edge to expiry. With bit 2 clear, it gives N+1 cycles.
- R7: Stage-1 expiry sets the timeout flag and starts stage 2 from the stage-2 preload.
- R8: When stage 2 expires with control bit 4 set, the block raises the warm reset request if bit 3 is set and the cold request otherwise. The request holds until reset, and the pin does not toggle.
- R9: When stage 2 expires with bit 4 clear, the timeout pin toggles unless bit 5 is set. Stage 1 then restarts.
- R10: After reset, all registers and outputs are zero, and the counter holds while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tout_flag | output | 1 | Stage-1 timeout flag |
| tout_pin | output | 1 | Timeout pin, toggled on stage-2 expiry |
| rst_req_warm | output | 1 | Sticky warm reset request |
| rst_req_cold | output | 1 | Sticky cold reset request |

## Verification
The bench attacks the key sequence. It sends a protected write with no key, a second write after one keyed write, a key interrupted by a control write, and a key with a wrong second byte. A design with a key that stays open, or one that resumes after an interruption, would accept those preloads. It measures the expiry cycle exactly in both prescaler modes, so an off-by-one in the "preload plus one" rule or in the fill of the fraction bits moves the flag by a cycle. It reloads during stage 2 to catch a design that keeps counting the old stage. It then checks the reset type, the toggle disable, and that a locked timer can be neither stopped nor reconfigured.

// File: rtl/wdog_pkg.sv
// Shared offsets, key bytes and control layout for the two-stage watchdog.
// Assumes a byte-offset bus where byte registers use data bits [7:0].
package wdog_pkg;
    localparam logic [4:0] OFS_PRE1 = 5'h00;
    localparam logic [4:0] OFS_PRE2 = 5'h04;
    localparam logic [4:0] OFS_KEY  = 5'h0C;
    localparam logic [4:0] OFS_CMD  = 5'h0D;
    localparam logic [4:0] OFS_CTRL = 5'h10;
    localparam logic [4:0] OFS_CNT  = 5'h14;
    localparam logic [4:0] OFS_LOCK = 5'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    typedef enum logic [1:0] {KG_IDLE, KG_HALF, KG_OPEN} kg_state_t;

    // Control bits [5:2] in order: toggle disable, reset enable, warm select, prescaler
    typedef struct packed {
        logic tog_dis;
        logic rst_en;
        logic warm;
        logic presc;
    } ctrl_t;
endpackage

// File: rtl/wdog_keygate.sv
// Unlock detector: tracks the two-byte key at the key offset and opens
// a one-write window. Any write that is not the next key byte closes it.
// Assumes one bus write per cycle at most.
module wdog_keygate
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [4:0] addr,
    input  logic [7:0] wbyte,
    output logic       key_open
);
    kg_state_t state_q;

    // Key state machine: every write either advances the key or drops it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KG_IDLE;
        end else if (wr) begin
            if (addr == OFS_KEY && wbyte == KEY_FIRST)
                state_q <= KG_HALF;
            else if (addr == OFS_KEY && wbyte == KEY_SECOND && state_q == KG_HALF)
                state_q <= KG_OPEN;
            else
                state_q <= KG_IDLE;
        end
    end

    assign key_open = (state_q == KG_OPEN);

    // R1: the window opens only right after the second key byte
    p_key_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_open) |-> $past(wr && addr == OFS_KEY && wbyte == KEY_SECOND));

    // R2: any write drops an open window
    p_key_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_open && wr) |=> !key_open);
endmodule

// File: rtl/wdog_regfile.sv
// Register file: preloads, control, lock/enable and the readback mux.
// Produces single-cycle start, reload and flag-clear strobes for the counter.
// Assumes key_open comes from the unlock detector in the same cycle.
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int PRE_W = 20,
    parameter int CNT_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [4:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             key_open,
    input  logic [CNT_W-1:0] cnt,
    input  logic             flag,
    output logic [PRE_W-1:0] pre1,
    output logic [PRE_W-1:0] pre2,
    output ctrl_t            ctrl,
    output logic             enable,
    output logic             start,
    output logic             reload,
    output logic             clr_flag,
    output logic [31:0]      rdata
);
    localparam int RD_SH = (CNT_W > 32) ? CNT_W - 32 : 0;

    logic             lock_q, en_q;
    logic [PRE_W-1:0] pre1_q, pre2_q;
    ctrl_t            ctrl_q;
    logic             prot_sel, prot_ok, lock_wr;
    logic [CNT_W-1:0] cnt_view;

    assign prot_sel = (addr == OFS_PRE1) || (addr == OFS_PRE2) || (addr == OFS_CMD);
    assign prot_ok  = wr && prot_sel && key_open;
    assign lock_wr  = wr && (addr == OFS_LOCK) && !lock_q;

    // Preload storage: keyed writes only, frozen by the lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre1_q <= '0;
            pre2_q <= '0;
        end else if (prot_ok && !lock_q) begin
            if (addr == OFS_PRE1) pre1_q <= wdata[PRE_W-1:0];
            if (addr == OFS_PRE2) pre2_q <= wdata[PRE_W-1:0];
        end
    end

    // Control register: plain write, frozen by the lock
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr && addr == OFS_CTRL && !lock_q)
            ctrl_q <= ctrl_t'(wdata[5:2]);
    end

    // Lock and enable: ignored once the lock bit is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (lock_wr) begin
            lock_q <= wdata[0];
            en_q   <= wdata[1];
        end
    end

    assign start    = lock_wr && wdata[1] && !en_q;
    assign reload   = prot_ok && (addr == OFS_CMD) && wdata[0];
    assign clr_flag = prot_ok && (addr == OFS_CMD) && wdata[1];
    assign pre1     = pre1_q;
    assign pre2     = pre2_q;
    assign ctrl     = ctrl_q;
    assign enable   = en_q;
    assign cnt_view = cnt >> RD_SH;

    // Readback mux by offset
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_PRE1: rdata = 32'(pre1_q);
            OFS_PRE2: rdata = 32'(pre2_q);
            OFS_KEY:  rdata[9] = flag;
            OFS_CTRL: rdata[5:2] = ctrl_q;
            OFS_CNT:  rdata = 32'(cnt_view);
            OFS_LOCK: rdata[1:0] = {en_q, lock_q};
            default:  rdata = '0;
        endcase
    end

    // R4: the lock bit is sticky until reset
    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R4: a locked timer cannot be switched off
    p_enable_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && en_q) |=> en_q);

    // R5: configuration does not move while locked
    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(ctrl_q) && $stable(pre1_q) && $stable(pre2_q)));
endmodule

// File: rtl/wdog_counter.sv
// Down counter and stage sequencer. Loads a preload into the upper bits
// (prescaler on, fraction filled with ones) or the lower bits (off), so a
// preload N lasts N+1 units. It drives the flag, the pin and the reset requests.
// Assumes start/reload/clr_flag are single-cycle strobes.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int PRE_W  = 20,
    parameter int FRAC_W = 15,
    localparam int CNT_W = PRE_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             reload,
    input  logic             clr_flag,
    input  ctrl_t            ctrl,
    input  logic [PRE_W-1:0] pre1,
    input  logic [PRE_W-1:0] pre2,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             pin,
    output logic             warm_req,
    output logic             cold_req
);
    logic [CNT_W-1:0] cnt_q;
    logic             stage2_q, flag_q, pin_q, warm_q, cold_q;
    logic             restart, at_zero, exp1, exp2;

    function automatic logic [CNT_W-1:0] load_val(input logic [PRE_W-1:0] p, input logic ps);
        if (ps) return {p, {FRAC_W{1'b1}}};
        return {{FRAC_W{1'b0}}, p};
    endfunction

    assign restart = start || reload;
    assign at_zero = (cnt_q == '0);
    assign exp1    = enable && !restart && at_zero && !stage2_q;
    assign exp2    = enable && !restart && at_zero && stage2_q;

    // Counter and stage: restart wins, else count down and switch stage at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            stage2_q <= 1'b0;
        end else if (restart) begin
            cnt_q    <= load_val(pre1, ctrl.presc);
            stage2_q <= 1'b0;
        end else if (enable) begin
            if (exp1) begin
                cnt_q    <= load_val(pre2, ctrl.presc);
                stage2_q <= 1'b1;
            end else if (exp2) begin
                cnt_q    <= load_val(pre1, ctrl.presc);
                stage2_q <= 1'b0;
            end else begin
                cnt_q    <= cnt_q - 1'b1;
            end
        end
    end

    // Timeout flag: set on stage-1 expiry, cleared by command
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (exp1)     flag_q <= 1'b1;
        else if (clr_flag) flag_q <= 1'b0;
    end

    // Stage-2 action: sticky reset request or pin toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            warm_q <= 1'b0;
            cold_q <= 1'b0;
        end else if (exp2) begin
            if (ctrl.rst_en) begin
                if (ctrl.warm) warm_q <= 1'b1;
                else           cold_q <= 1'b1;
            end else if (!ctrl.tog_dis) begin
                pin_q <= !pin_q;
            end
        end
    end

    assign cnt      = cnt_q;
    assign flag     = flag_q;
    assign pin      = pin_q;
    assign warm_req = warm_q;
    assign cold_req = cold_q;

    // R7: stage-1 expiry always leaves the flag set
    p_flag_on_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp1 |=> (flag_q && stage2_q));

    // R8: reset requests hold and never both rise
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q || cold_q) |=> (warm_q || cold_q));
    p_req_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(warm_q && cold_q));

    // R9: the pin only moves on a stage-2 expiry with reset disabled
    p_pin_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q != $past(pin_q)) |-> $past(exp2 && !ctrl.rst_en));
endmodule

// File: rtl/wdog_twostage.sv
// Top of the key-protected two-stage watchdog: joins the unlock detector,
// the register file and the counter. Assumes a single clock domain.
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int PRE_W  = 20,
    parameter int FRAC_W = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tout_flag,
    output logic        tout_pin,
    output logic        rst_req_warm,
    output logic        rst_req_cold
);
    localparam int CNT_W = PRE_W + FRAC_W;

    logic             key_open, enable, start, reload, clr_flag, flag;
    logic [PRE_W-1:0] pre1, pre2;
    logic [CNT_W-1:0] cnt;
    ctrl_t            ctrl;

    wdog_keygate u_key (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wbyte(bus_wdata[7:0]), .key_open(key_open)
    );

    wdog_regfile #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .key_open(key_open), .cnt(cnt), .flag(flag), .pre1(pre1), .pre2(pre2),
        .ctrl(ctrl), .enable(enable), .start(start), .reload(reload),
        .clr_flag(clr_flag), .rdata(bus_rdata)
    );

    wdog_counter #(.PRE_W(PRE_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .reload(reload),
        .clr_flag(clr_flag), .ctrl(ctrl), .pre1(pre1), .pre2(pre2), .cnt(cnt),
        .flag(flag), .pin(tout_pin), .warm_req(rst_req_warm), .cold_req(rst_req_cold)
    );

    assign tout_flag = flag;
endmodule

// File: tb/wdog_twostage_test.sv
// Directed bench: one task per scenario, each checking its own results.
module wdog_twostage_test;
    localparam int FRAC = 3;
    localparam int UNIT = 1 << FRAC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tout_flag, tout_pin, rst_req_warm, rst_req_cold;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdog_twostage #(.PRE_W(20), .FRAC_W(FRAC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tout_flag(tout_flag),
        .tout_pin(tout_pin), .rst_req_warm(rst_req_warm), .rst_req_cold(rst_req_cold)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    // One write: driven at the falling edge, taken at the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic key();
        wr(5'h0C, 32'h80); wr(5'h0C, 32'h86);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(5'h18, v); chk(v == 0, "R10 lock reg", v, 0);
        rd(5'h10, v); chk(v == 0, "R10 ctrl reg", v, 0);
        rd(5'h00, v); chk(v == 0, "R10 preload", v, 0);
        repeat (10) @(posedge clk); #1;
        rd(5'h14, v); chk(v == 0, "R10 counter held", v, 0);
        chk({tout_flag, tout_pin, rst_req_warm, rst_req_cold} == 0, "R10 outputs",
            {tout_flag, tout_pin, rst_req_warm, rst_req_cold}, 0);
    endtask

    task automatic t_key();
        logic [31:0] v;
        do_reset();
        wr(5'h00, 32'd7);
        rd(5'h00, v); chk(v == 0, "R2 unkeyed write dropped", v, 0);
        key(); wr(5'h00, 32'd5);
        rd(5'h00, v); chk(v == 5, "R1 keyed write taken", v, 5);
        wr(5'h00, 32'd9);
        rd(5'h00, v); chk(v == 5, "R1 single write per key", v, 5);
        wr(5'h0C, 32'h80); wr(5'h10, 32'h0); wr(5'h0C, 32'h86); wr(5'h00, 32'd11);
        rd(5'h00, v); chk(v == 5, "R2 interrupted key", v, 5);
        wr(5'h0C, 32'h80); wr(5'h0C, 32'h87); wr(5'h0C, 32'h86); wr(5'h00, 32'd12);
        rd(5'h00, v); chk(v == 5, "R2 wrong second byte", v, 5);
        key(); wr(5'h04, 32'hABCDE);
        rd(5'h04, v); chk(v == 32'hABCDE, "R1 stage-2 preload", v, 32'hABCDE);
    endtask

    task automatic t_timing_direct();
        logic [31:0] v;
        do_reset();
        key(); wr(5'h00, 32'd5);
        key(); wr(5'h04, 32'd3);
        wr(5'h10, 32'h00);
        wr(5'h18, 32'h02);
        repeat (5) @(posedge clk); #1;
        chk(tout_flag == 0, "R6 flag not yet (direct)", tout_flag, 0);
        @(posedge clk); #1;
        chk(tout_flag == 1, "R6 R7 flag at N+1 cycles", tout_flag, 1);
        repeat (3) @(posedge clk); #1;
        chk(tout_pin == 0, "R9 pin before stage-2 end", tout_pin, 0);
        @(posedge clk); #1;
        chk(tout_pin == 1, "R9 pin toggles", tout_pin, 1);
        chk(rst_req_warm == 0 && rst_req_cold == 0, "R9 no reset request",
            {rst_req_warm, rst_req_cold}, 0);
        key(); wr(5'h0D, 32'h02);
        chk(tout_flag == 0, "R3 flag cleared", tout_flag, 0);
        rd(5'h0C, v); chk(v[9] == 0, "R3 flag readback", v[9], 0);
    endtask

    task automatic t_timing_presc();
        do_reset();
        key(); wr(5'h00, 32'd2);
        key(); wr(5'h04, 32'd3);
        wr(5'h10, 32'h04);
        wr(5'h18, 32'h02);
        repeat (3 * UNIT - 1) @(posedge clk); #1;
        chk(tout_flag == 0, "R6 flag not yet (prescaled)", tout_flag, 0);
        @(posedge clk); #1;
        chk(tout_flag == 1, "R6 flag at (N+1)*unit", tout_flag, 1);
        key(); wr(5'h0D, 32'h03);
        chk(tout_flag == 0, "R3 reload and clear", tout_flag, 0);
        repeat (3 * UNIT - 1) @(posedge clk); #1;
        chk(tout_flag == 0, "R3 restarted stage 1 not done", tout_flag, 0);
        @(posedge clk); #1;
        chk(tout_flag == 1, "R3 restarted stage 1 expires", tout_flag, 1);
        repeat (6) @(posedge clk); #1;
        chk(tout_pin == 0, "R3 old stage 2 abandoned", tout_pin, 0);
    endtask

    task automatic t_reset_kind(input bit warm);
        do_reset();
        wr(5'h10, warm ? 32'h18 : 32'h10);
        wr(5'h18, 32'h02);
        @(posedge clk); #1;
        chk(tout_flag == 1, "R7 flag with zero preload", tout_flag, 1);
        @(posedge clk); #1;
        chk(rst_req_warm == warm, "R8 warm request", rst_req_warm, warm);
        chk(rst_req_cold == !warm, "R8 cold request", rst_req_cold, !warm);
        repeat (12) @(posedge clk); #1;
        chk((rst_req_warm || rst_req_cold) && tout_pin == 0, "R8 request held, pin still",
            {rst_req_warm, rst_req_cold, tout_pin}, 0);
    endtask

    task automatic t_toggle_off();
        do_reset();
        wr(5'h10, 32'h20);
        wr(5'h18, 32'h02);
        repeat (6) @(posedge clk); #1;
        chk(tout_pin == 0, "R9 toggle disabled", tout_pin, 0);
        chk(tout_flag == 1 && !rst_req_warm && !rst_req_cold, "R9 flag only",
            {tout_flag, rst_req_warm, rst_req_cold}, 4);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        key(); wr(5'h00, 32'd1);
        key(); wr(5'h04, 32'd40);
        wr(5'h18, 32'h03);
        rd(5'h18, v); chk(v == 3, "R4 lock set", v, 3);
        wr(5'h18, 32'h00);
        rd(5'h18, v); chk(v == 3, "R4 disable ignored", v, 3);
        wr(5'h10, 32'h3C);
        rd(5'h10, v); chk(v == 0, "R5 ctrl frozen", v, 0);
        key(); wr(5'h00, 32'd7);
        rd(5'h00, v); chk(v == 1, "R5 preload frozen", v, 1);
        chk(tout_flag == 1, "R4 timer still running", tout_flag, 1);
        key(); wr(5'h0D, 32'h02);
        chk(tout_flag == 0, "R5 command works while locked", tout_flag, 0);
        do_reset();
        rd(5'h18, v); chk(v == 0, "R4 reset clears lock", v, 0);
    endtask

    initial begin
        t_reset();
        t_key();
        t_timing_direct();
        t_timing_presc();
        t_reset_kind(1'b1);
        t_reset_kind(1'b0);
        t_toggle_off();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule